// File: doc/BRIEF.md
# Serial Display Command and Data Writer

This block is a write-only serial transmitter that feeds a display controller over four lines: an active-low chip select (`csn_o`), a register select (`sel_o`, low for the instruction register, high for the data register), a serial clock (`sck_o`) and serial data (`sdo_o`). A transfer is opened with a one-cycle `start_i` pulse. The pulse carries the kind of transfer and, for data, the number of bytes. The bytes then arrive one at a time over a valid/ready stream. Each byte goes out MSB first. For every bit, the clock falls together with the new data level, then rises while the data is held.

A command transfer always moves exactly one byte with the select line low. A data transfer moves `count_i` bytes with the select line high. Chip select stays low without a break from the start of the transfer to the end of its last byte. After that, all four lines return high on the same edge on which `busy_o` falls and `done_o` pulses. The parameter `HALF_CYC` sets the length, in system clock cycles, of each low phase and each high phase of the serial clock.

Top module: `panel_link_tx`

## Requirements
- R1: Bits leave MSB first; `sdo_o` changes only on the edge where `sck_o` falls, and stays stable while `sck_o` is high during a transfer.
- R2: With `is_data_i` = 0 the block sends exactly one byte with `sel_o` low throughout, whatever `count_i` holds.
- R3: With `is_data_i` = 1 the block sends exactly `count_i` bytes with `sel_o` high throughout the transfer.
- R4: `csn_o` goes low once per transfer and stays low across every byte of a burst; `busy_o` is high whenever `csn_o` is low.
- R5: On the edge after the eighth rising clock edge of the last byte plus one high phase, all four lines go high, `busy_o` falls and `done_o` is high for exactly one cycle.
- R6: `byte_ready_o` is high only while the block waits for the next byte; it is low while any bit of a byte is being shifted.
- R7: Every low phase of `sck_o` lasts exactly `HALF_CYC` system cycles, and every high phase that falls inside a byte lasts exactly `HALF_CYC` cycles.
- R8: When idle, all four lines are high, `busy_o`, `byte_ready_o` and `done_o` are low, and a data start with `count_i` = 0 is ignored.
- R9: A `start_i` pulse while a transfer is in progress is ignored.
- R10: Asserting `rst_n` low forces all four lines high and `busy_o` low at once, and abandons any burst; the block then accepts new transfers normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to open a transfer |
| is_data_i | input | 1 | 1 = data burst, 0 = single command byte |
| count_i | input | CNT_W | Byte count of a data burst |
| byte_valid_i | input | 1 | Byte on `byte_data_i` is offered |
| byte_data_i | input | 8 | Byte to send |
| byte_ready_o | output | 1 | Block takes the offered byte at this edge |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the lines have returned high |
| csn_o | output | 1 | Chip select, active low |
| sel_o | output | 1 | Register select: 0 instruction, 1 data |
| sck_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data, idles high |

## Verification
A scoreboard rebuilds each byte from `sdo_o` at the rising edges of `sck_o` and compares it, together with the select level at the eighth edge, against the expected queue. Bit-reversed shifting or a select that follows the wrong kind of transfer shows up there as a mismatch. The bench sends all-zero, all-one and single-bit bytes, and a command whose count field is large. A design that honours that count sends extra bytes. The bench counts rising edges of chip select across a three-byte burst: a design that releases chip select between bytes produces more than one. It also measures the clock phase lengths, which catches a divider that is off by one. Finally it sends a zero-count data start, a start pulse during a transfer and a reset in the middle of a burst. A design that mishandles these raises `busy_o`, restarts or corrupts a transfer, or leaves the lines low.

// File: rtl/plw_pkg.sv
package plw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } plw_state_e;

  typedef struct packed {
    logic csn;
    logic sel;
    logic sck;
    logic sdo;
  } plw_lines_t;

  localparam plw_lines_t LINES_IDLE = '{csn: 1'b1, sel: 1'b1, sck: 1'b1, sdo: 1'b1};
endpackage

// File: rtl/plw_halfdiv.sv
module plw_halfdiv #(
  parameter int HALF_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expire
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (restart) begin
      cnt_en = 1'b1;
      cnt_d  = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/plw_shifter.sv
module plw_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift,
  output logic         next_bit,
  output logic         last
);
  localparam int BCW = $clog2(W);
  localparam logic [BCW-1:0] BITS_TOP = BCW'(W - 1);

  logic [W-1:0]   sreg_q, sreg_d;
  logic [BCW-1:0] left_q, left_d;
  logic           en;

  always_comb begin
    en     = load | shift;
    sreg_d = sreg_q;
    left_d = left_q;
    if (load) begin
      sreg_d = load_data;
      left_d = BITS_TOP;
    end else if (shift) begin
      sreg_d = {sreg_q[W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      left_q <= '0;
    end else if (en) begin
      sreg_q <= sreg_d;
      left_q <= left_d;
    end
  end

  assign next_bit = sreg_q[W-2];
  assign last     = (left_q == '0);
endmodule

// File: rtl/panel_link_tx.sv
module panel_link_tx #(
  parameter int HALF_CYC = 3,
  parameter int CNT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             is_data_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             csn_o,
  output logic             sel_o,
  output logic             sck_o,
  output logic             sdo_o
);
  import plw_pkg::*;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  plw_state_e       state_q, state_d;
  plw_lines_t       lines_q, lines_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             done_q, done_d;
  logic             restart, expire, load, shift, next_bit, last;
  logic             ctl_en;

  plw_halfdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .expire  (expire)
  );

  plw_shifter #(.W(8)) u_shf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load      (load),
    .load_data (byte_data_i),
    .shift     (shift),
    .next_bit  (next_bit),
    .last      (last)
  );

  always_comb begin
    state_d = state_q;
    lines_d = lines_q;
    rem_d   = rem_q;
    done_d  = 1'b0;
    restart = 1'b0;
    load    = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (!is_data_i || count_i != '0)) begin
          state_d = ST_WAIT;
          rem_d   = is_data_i ? count_i : ONE;
          lines_d = '{csn: 1'b0, sel: is_data_i, sck: 1'b1, sdo: 1'b1};
        end
      end
      ST_WAIT: begin
        if (byte_valid_i) begin
          load        = 1'b1;
          restart     = 1'b1;
          lines_d.sck = 1'b0;
          lines_d.sdo = byte_data_i[7];
          state_d     = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (expire) begin
          if (!lines_q.sck) begin
            lines_d.sck = 1'b1;
            restart     = 1'b1;
          end else if (!last) begin
            shift       = 1'b1;
            restart     = 1'b1;
            lines_d.sck = 1'b0;
            lines_d.sdo = next_bit;
          end else if (rem_q == ONE) begin
            state_d = ST_IDLE;
            lines_d = LINES_IDLE;
            rem_d   = '0;
            done_d  = 1'b1;
          end else begin
            rem_d   = rem_q - 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        lines_d = LINES_IDLE;
      end
    endcase
  end

  assign ctl_en = (state_d != state_q) || (lines_d != lines_q) ||
                  (rem_d != rem_q) || (done_d != done_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      lines_q <= LINES_IDLE;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      lines_q <= lines_d;
      rem_q   <= rem_d;
      done_q  <= done_d;
    end
  end

  assign byte_ready_o = (state_q == ST_WAIT);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign csn_o        = lines_q.csn;
  assign sel_o        = lines_q.sel;
  assign sck_o        = lines_q.sck;
  assign sdo_o        = lines_q.sdo;
endmodule

// File: rtl/plw_checker.sv
module plw_checker (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic sel,
  input logic sck,
  input logic sdo,
  input logic busy,
  input logic ready,
  input logic done
);
  AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && sck && $past(sck)) |-> $stable(sdo)) else $error("sdo moved while sck high"); // R1

  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && !$past(csn)) |-> $stable(sel)) else $error("sel moved mid transfer"); // R3

  AST_CS_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !csn |-> busy) else $error("csn low while not busy"); // R4

  AST_DONE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (csn && sel && sck && sdo && !busy)) else $error("done with lines not idle"); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R5

  AST_NO_READY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && !sck) |-> !ready) else $error("ready during shift"); // R6

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (csn && sel && sck && sdo && !ready)) else $error("idle lines not high"); // R8
endmodule

bind panel_link_tx plw_checker u_plw_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .csn   (csn_o),
  .sel   (sel_o),
  .sck   (sck_o),
  .sdo   (sdo_o),
  .busy  (busy_o),
  .ready (byte_ready_o),
  .done  (done_o)
);

// File: tb/panel_link_tx_bench.sv
`timescale 1ns/1ps
module panel_link_tx_bench;
  localparam int HALF  = 3;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             is_data_i = 1'b0;
  logic [CNT_W-1:0] count_i = '0;
  logic             byte_valid_i = 1'b0;
  logic [7:0]       byte_data_i = '0;
  logic             byte_ready_o, busy_o, done_o, csn_o, sel_o, sck_o, sdo_o;

  always #2 clk = ~clk;

  panel_link_tx #(.HALF_CYC(HALF), .CNT_W(CNT_W)) u_panel_link_tx (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];
  logic [7:0] pat[8];
  int rx_bytes = 0;
  int csn_rises = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: rebuilds bytes from the serial lines and pops the scoreboard
  logic       prev_sck = 1'b1, prev_csn = 1'b1, prev_done = 1'b0;
  logic [7:0] shreg = '0;
  int         bitcnt = 0, low_run = 0, high_run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (csn_o && !prev_csn) csn_rises++;
      if (csn_o) begin
        bitcnt = 0; low_run = 0; high_run = 0;
      end else begin
        if (!sck_o) begin
          if (prev_sck && bitcnt > 0 && bitcnt < 8)
            chk(high_run == HALF, "R7", "sck high phase", high_run, HALF);
          low_run++;
          if (byte_ready_o) chk(1'b0, "R6", "ready while shifting", 1, 0);
        end else begin
          if (!prev_sck) begin
            chk(low_run == HALF, "R7", "sck low phase", low_run, HALF);
            low_run  = 0;
            high_run = 0;
            shreg    = {shreg[6:0], sdo_o};
            bitcnt++;
            if (bitcnt == 8) begin
              rx_bytes++;
              if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected byte", {sel_o, shreg}, 0);
              else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk({sel_o, shreg} == e, "R1", "byte and select", {sel_o, shreg}, e);
              end
              bitcnt = 0;
            end
          end
          high_run++;
        end
        if (!busy_o) chk(1'b0, "R4", "csn low while idle", 0, 1);
      end
      if (done_o) begin
        chk({csn_o, sel_o, sck_o, sdo_o, busy_o} == 5'b11110, "R5", "lines at done",
            {csn_o, sel_o, sck_o, sdo_o, busy_o}, 5'b11110);
        if (prev_done) chk(1'b0, "R5", "done two cycles", 1, 0);
      end
      prev_sck  = sck_o;
      prev_csn  = csn_o;
      prev_done = done_o;
    end else begin
      prev_sck = 1'b1; prev_csn = 1'b1; prev_done = 1'b0;
      bitcnt = 0; low_run = 0; high_run = 0;
    end
  end

  task automatic xfer(input bit dat, input int cnt_field, input int n);
    @(negedge clk);
    start_i = 1'b1; is_data_i = dat; count_i = CNT_W'(cnt_field);
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({dat, pat[i]});
      byte_valid_i = 1'b1;
      byte_data_i  = pat[i];
      while (!byte_ready_o) @(negedge clk);
      @(negedge clk);
      byte_valid_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // reset state
    chk({csn_o, sel_o, sck_o, sdo_o} == 4'hF, "R10", "lines in reset",
        {csn_o, sel_o, sck_o, sdo_o}, 4'hF);
    chk({busy_o, byte_ready_o, done_o} == 3'b000, "R8", "flags in reset",
        {busy_o, byte_ready_o, done_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: command, count field ignored
    pat[0] = 8'hA5;
    xfer(1'b0, 5, 1);
    chk(exp_q.size() == 0, "R2", "command bytes left", exp_q.size(), 0);
    chk(rx_bytes == 1, "R2", "command byte count", rx_bytes, 1);

    // R1: single-bit patterns reveal bit order
    pat[0] = 8'h80; pat[1] = 8'h01;
    xfer(1'b1, 2, 2);

    // R3 / R4: three-byte data burst, one csn rise
    r0 = csn_rises;
    pat[0] = 8'h00; pat[1] = 8'hFF; pat[2] = 8'h3C;
    xfer(1'b1, 3, 3);
    chk(csn_rises - r0 == 1, "R4", "csn rises in burst", csn_rises - r0, 1);
    chk(rx_bytes == 6, "R3", "burst byte total", rx_bytes, 6);

    // R8: data start with zero count
    @(negedge clk);
    start_i = 1'b1; is_data_i = 1'b1; count_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    chk({busy_o, csn_o} == 2'b01, "R8", "zero count ignored", {busy_o, csn_o}, 1);

    // R9: start pulse during a command
    @(negedge clk);
    start_i = 1'b1; is_data_i = 1'b0; count_i = 1;
    @(negedge clk);
    start_i = 1'b0;
    exp_q.push_back({1'b0, 8'h5A});
    byte_valid_i = 1'b1; byte_data_i = 8'h5A;
    while (!byte_ready_o) @(negedge clk);
    @(negedge clk);
    byte_valid_i = 1'b0;
    repeat (4) @(negedge clk);
    start_i = 1'b1; is_data_i = 1'b1; count_i = 2;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (40) @(negedge clk);
    chk({busy_o, csn_o} == 2'b01, "R9", "no transfer after busy start", {busy_o, csn_o}, 1);
    chk(rx_bytes == 7 && exp_q.size() == 0, "R9", "bytes after busy start", rx_bytes, 7);

    // R10: reset in the middle of a burst
    @(negedge clk);
    start_i = 1'b1; is_data_i = 1'b1; count_i = 3;
    @(negedge clk);
    start_i = 1'b0;
    byte_valid_i = 1'b1; byte_data_i = 8'hC3;
    while (!byte_ready_o) @(negedge clk);
    @(negedge clk);
    byte_valid_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({csn_o, sel_o, sck_o, sdo_o, busy_o} == 5'b11110, "R10", "lines on mid reset",
        {csn_o, sel_o, sck_o, sdo_o, busy_o}, 5'b11110);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pat[0] = 8'h3C;
    xfer(1'b0, 0, 1);
    chk(exp_q.size() == 0 && rx_bytes == 8, "R10", "recovery command", rx_bytes, 8);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog timeout actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule